// File: doc/BRIEF.md
# Serial Unlock Access Gate

This block sits on an asynchronous-style SRAM bus, with active-low chip enable, output enable and write enable strobes sampled on the system clock. It decides whether each bus cycle goes to the memory array or to a hidden timekeeping register file. By default every cycle goes to memory. A hidden target opens only after a fixed serial key arrives one bit per write cycle on data bit 0. The key writes themselves still reach memory, so software normally reserves one scratch word for them.

The attempt starts with a read cycle. A wrong bit stalls the attempt until the next read. Once every key bit has matched, a fixed number of following cycles reach the timekeeping port instead of memory. A write in that window shifts one bit in. A read presents one bit on data bit 0 and advances the port. After the window the gate returns to memory routing and the key must be sent again. An inhibit input, for example a power-fail flag, blocks all routing and clears the recognition state.

A cycle is taken as complete on the clock edge where chip enable is seen deasserted. A cycle that saw write enable is a write. A cycle that saw only output enable is a read.

Top module: `unlock_gate`

## Requirements
- R1: While reset is asserted and right after it, mem_en, rtc_sel, dout_en, rtc_wr_stb and rtc_rd_stb are all 0 and dout is 0.
- R2: Outside the transfer window, every cycle with chip enable low (and inhibit low) raises mem_en one clock after chip enable is sampled low, and rtc_sel stays 0. This includes the key writes.
- R3: Key bits are taken from parameter KEY starting at bit 0 and moving upward. A write whose din[0] equals the key bit at the pointer advances the pointer. A match on bit KEY_LEN-1 opens the transfer window starting with the next bus cycle.
- R4: A write whose din[0] differs from the key bit at the pointer leaves the pointer unchanged. All later writes are then ignored for recognition until a read cycle, so correct bits sent afterwards never open the window.
- R5: A read cycle outside the window returns the pointer to key bit 0 and clears a prior mismatch. Only a complete key sent after the read opens the window.
- R6: In the window, a write cycle raises rtc_sel instead of mem_en. After the cycle ends, it gives a one-clock rtc_wr_stb with rtc_wr_bit equal to the din[0] of that cycle.
- R7: In the window, a read cycle raises dout_en with dout equal to rtc_bit in bit 0 and zero in all other bits. After the cycle ends, it gives a one-clock rtc_rd_stb. When dout_en is 0, dout is 0.
- R8: After XFER_LEN cycles in the window, routing returns to memory and the pointer is at bit 0, so a new full key is needed to reopen the window.
- R9: While inhibit is high, mem_en, rtc_sel, dout_en and both strobes are 0 from the next clock on. Any partial key is discarded and an open window is closed.
- R10: mem_en and rtc_sel are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inhibit | input | 1 | Blocks all routing and clears recognition |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| din | input | DW | Bus write data; only bit 0 is used |
| rtc_bit | input | 1 | Current output bit of the timekeeping port |
| mem_en | output | 1 | Memory array select |
| rtc_sel | output | 1 | Timekeeping port select |
| dout | output | DW | Read data driven during window reads |
| dout_en | output | 1 | Bus drive enable for dout |
| rtc_wr_stb | output | 1 | One-clock shift-in strobe to the timekeeping port |
| rtc_wr_bit | output | 1 | Bit shifted in with rtc_wr_stb |
| rtc_rd_stb | output | 1 | One-clock advance strobe after a window read |

## Verification
The hardest state to reach is a mismatch on the very last key bit, which must still leave the gate routing to memory after 63 correct writes. The bench gets there by sweeping the flipped position over every one of the 64 key bits, each attempt preceded by a read. After each attempt it sends one more write and checks it lands in memory. A reference model of the pointer, the mismatch flag and the window counter gives the expected routing for every cycle. The same model covers reads in the middle of a key, an inhibit pulse during a partial key, and an inhibit pulse inside an open window.

// File: rtl/unlock_gate.sv
module unlock_gate #(
  parameter int KEY_LEN = 64,
  parameter logic [KEY_LEN-1:0] KEY = 64'hC3A5_96F0_1E2D_4B78,
  parameter int XFER_LEN = 64,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inhibit,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  input  logic          rtc_bit,
  output logic          mem_en,
  output logic          rtc_sel,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          rtc_wr_stb,
  output logic          rtc_wr_bit,
  output logic          rtc_rd_stb
);
  localparam int PW = $clog2(KEY_LEN);
  localparam int CW = $clog2(XFER_LEN);

  logic          in_cyc, seen_wr, seen_rd, wbit, fail, xfer;
  logic [PW-1:0] ptr;
  logic [CW-1:0] cnt;

  wire active  = ~ce_n & ~inhibit;
  wire cyc_end = in_cyc & ~active & ~inhibit;
  wire is_wr   = seen_wr;
  wire is_rd   = seen_rd & ~seen_wr;
  wire drive   = active & xfer & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cyc <= 1'b0; seen_wr <= 1'b0; seen_rd <= 1'b0; wbit <= 1'b0;
      fail <= 1'b0; xfer <= 1'b0; ptr <= '0; cnt <= '0;
      mem_en <= 1'b0; rtc_sel <= 1'b0; dout <= '0; dout_en <= 1'b0;
      rtc_wr_stb <= 1'b0; rtc_wr_bit <= 1'b0; rtc_rd_stb <= 1'b0;
    end else begin
      in_cyc     <= active;
      mem_en     <= active & ~xfer;
      rtc_sel    <= active & xfer;
      dout_en    <= drive;
      dout       <= drive ? {{(DW-1){1'b0}}, rtc_bit} : '0;
      rtc_wr_stb <= 1'b0;
      rtc_rd_stb <= 1'b0;
      if (active) begin
        seen_wr <= seen_wr | ~we_n;
        seen_rd <= seen_rd | ~oe_n;
        if (!we_n) wbit <= din[0];
      end
      if (inhibit) begin
        seen_wr <= 1'b0; seen_rd <= 1'b0;
        ptr <= '0; fail <= 1'b0; xfer <= 1'b0; cnt <= '0;
      end else if (cyc_end) begin
        seen_wr <= 1'b0; seen_rd <= 1'b0;
        if (xfer) begin
          if (is_wr) begin
            rtc_wr_stb <= 1'b1;
            rtc_wr_bit <= wbit;
          end else if (is_rd) begin
            rtc_rd_stb <= 1'b1;
          end
          if (is_wr | is_rd) begin
            if (cnt == CW'(XFER_LEN - 1)) begin
              xfer <= 1'b0; cnt <= '0; ptr <= '0; fail <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end else if (is_rd) begin
          ptr  <= '0;
          fail <= 1'b0;
        end else if (is_wr && !fail) begin
          if (wbit == KEY[ptr]) begin
            if (ptr == PW'(KEY_LEN - 1)) begin
              xfer <= 1'b1; ptr <= '0; cnt <= '0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end else begin
            fail <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/unlock_gate_chk.sv
module unlock_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inhibit,
  input logic          ce_n,
  input logic          mem_en,
  input logic          rtc_sel,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          rtc_wr_stb,
  input logic          rtc_rd_stb
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && rtc_sel));
  a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!mem_en && !rtc_sel && !dout_en && !rtc_wr_stb && !rtc_rd_stb));
  a_r7_dout_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> ((dout >> 1) == '0));
  a_r7_dout_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_wr_stb |=> !rtc_wr_stb);
  a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_rd_stb |=> !rtc_rd_stb);
  a_r6_strobe_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_wr_stb || rtc_rd_stb) |-> (!rtc_sel && !mem_en && !(rtc_wr_stb && rtc_rd_stb)));
  a_r2_mem_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(!ce_n));
endmodule

bind unlock_gate unlock_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .ce_n(ce_n),
  .mem_en(mem_en), .rtc_sel(rtc_sel), .dout(dout), .dout_en(dout_en),
  .rtc_wr_stb(rtc_wr_stb), .rtc_rd_stb(rtc_rd_stb)
);

// File: tb/unlock_gate_bench.sv
`timescale 1ns/1ps
module unlock_gate_bench;
  localparam int KL = 64;
  localparam logic [KL-1:0] K = 64'hC3A5_96F0_1E2D_4B78;
  localparam int XL = 64;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, inhibit = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rtc_bit = 1'b0;
  logic [DW-1:0] din = '0;
  logic mem_en, rtc_sel, dout_en, rtc_wr_stb, rtc_wr_bit, rtc_rd_stb;
  logic [DW-1:0] dout;

  int errors = 0, checks = 0;
  int ptr_m = 0, cnt_m = 0;
  bit fail_m = 0, xfer_m = 0, done = 0;

  always #2.5 clk = ~clk;

  unlock_gate #(.KEY_LEN(KL), .KEY(K), .XFER_LEN(XL), .DW(DW)) u_unlock_gate (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .din(din), .rtc_bit(rtc_bit), .mem_en(mem_en),
    .rtc_sel(rtc_sel), .dout(dout), .dout_en(dout_en), .rtc_wr_stb(rtc_wr_stb),
    .rtc_wr_bit(rtc_wr_bit), .rtc_rd_stb(rtc_rd_stb));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input bit wr, input bit b);
    if (xfer_m) begin
      cnt_m++;
      if (cnt_m == XL) begin xfer_m = 0; cnt_m = 0; ptr_m = 0; fail_m = 0; end
    end else if (!wr) begin
      ptr_m = 0; fail_m = 0;
    end else if (!fail_m) begin
      if (b == K[ptr_m]) begin
        if (ptr_m == KL - 1) begin xfer_m = 1; ptr_m = 0; end else ptr_m++;
      end else fail_m = 1;
    end
  endtask

  task automatic cyc(input bit wr, input bit b);
    bit x = xfer_m;
    @(negedge clk);
    ce_n = 1'b0; we_n = ~wr; oe_n = wr; din = {7'b1010110, b};
    @(negedge clk);
    @(negedge clk);
    check(mem_en == !x, x ? "R6 mem blocked in window" : "R2 mem routing", mem_en, !x);
    check(rtc_sel == x, x ? "R3 window open" : "R4/R5 window closed", rtc_sel, x);
    check(dout_en == (x && !wr), "R7 dout_en", dout_en, x && !wr);
    check(dout == ((x && !wr) ? DW'(rtc_bit) : '0), "R7 dout value", dout,
          (x && !wr) ? rtc_bit : 0);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    check(rtc_wr_stb == (x && wr), "R6 write strobe", rtc_wr_stb, x && wr);
    if (x && wr) check(rtc_wr_bit == b, "R6 write bit", rtc_wr_bit, b);
    check(rtc_rd_stb == (x && !wr), "R7 read strobe", rtc_rd_stb, x && !wr);
    model(wr, b);
  endtask

  task automatic send_key(input int flip, input int from);
    for (int i = from; i < KL; i++) cyc(1'b1, K[i] ^ (i == flip));
  endtask

  task automatic window();
    for (int i = 0; i < XL; i++) begin
      rtc_bit = i[1] ^ i[0];
      cyc(i[0], i[2]);
    end
  endtask

  task automatic pulse_inhibit();
    @(negedge clk);
    inhibit = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!mem_en && !rtc_sel && !dout_en, "R9 inhibit blocks", {mem_en, rtc_sel, dout_en}, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    inhibit = 1'b0;
    @(negedge clk);
    ptr_m = 0; fail_m = 0; xfer_m = 0; cnt_m = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_en && !rtc_sel && !dout_en && !rtc_wr_stb && !rtc_rd_stb && dout == 0,
          "R1 reset state", mem_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_en && !rtc_sel && !rtc_wr_stb && !rtc_rd_stb, "R1 after reset", rtc_sel, 0);

    // R3 full key opens the window; R6/R7 transfers; R8 return to memory
    cyc(1'b0, 1'b0);
    send_key(-1, 0);
    check(xfer_m == 1, "R3 model reached window", xfer_m, 1);
    window();
    cyc(1'b1, K[0]);
    cyc(1'b1, 1'b0);

    // R4 sweep of mismatch position over every key bit
    for (int p = 0; p < KL; p++) begin
      cyc(1'b0, 1'b0);
      send_key(p, 0);
      cyc(1'b1, 1'b1);
    end

    // R5 read mid-key restarts; continuation without restart fails
    cyc(1'b0, 1'b0);
    send_key(-1, 34);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b1, K[i]);
    cyc(1'b0, 1'b0);
    send_key(-1, 0);
    window();

    // R9 inhibit discards a partial key
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) cyc(1'b1, K[i]);
    pulse_inhibit();
    send_key(-1, 40);
    cyc(1'b1, 1'b0);

    // R9 inhibit closes an open window
    cyc(1'b0, 1'b0);
    send_key(-1, 0);
    for (int i = 0; i < 10; i++) cyc(i[0], 1'b1);
    pulse_inhibit();
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule